// File: doc/BRIEF.md
# Comparator event interrupt controller

This block is the digital control that sits around the one-bit output of an analog comparator. It brings the asynchronous comparator output into the clock domain and keeps an 8-bit control/status register. From that register it drives the comparator power-down and reference-select controls. It detects rising, falling or any-toggle events on the synchronized level and latches them in a sticky flag. The flag raises an interrupt request when both the local enable and the global enable are set. When routing is enabled, the block also passes the synchronized level on as a trigger for an external capture unit.

Software writes the register in a single cycle and can read it back at any time. The flag is cleared in one of two ways: by writing a one to its bit, or by the interrupt vector acknowledge. While the comparator is powered down, the synchronizer freezes, so switching the power off or on does not produce false events.

Register layout used below: bit 0 power-off, bit 1 reference select, bit 2 capture route, bit 3 interrupt enable, bits 5:4 event mode, bit 6 event flag, bit 7 comparator level (read-only).

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset, rd_data_o reads 0x00 while cmp_i is low, and irq_o, cap_trig_o, pwr_off_o and ref_sel_o are all 0.
- R2: A write with wr_en_i stores wr_data_i[5:0] into bits 5:0, visible on rd_data_o after the next clock edge. Writes to bit 7 are ignored.
- R3: Bit 7 of rd_data_o shows the comparator level SYNC_STAGES clock edges after cmp_i changes, provided the comparator is powered.
- R4: With mode 2'b00, both a rising and a falling level change set the flag (bit 6). The flag becomes visible one edge after the level bit changes.
- R5: With mode 2'b10, only a falling level change sets the flag.
- R6: With mode 2'b11, only a rising level change sets the flag.
- R7: Mode 2'b01 is reserved and never sets the flag.
- R8: Writing 1 to bit 6 clears the flag. Writing 0 to bit 6 leaves it unchanged.
- R9: A one-cycle pulse on vec_ack_i clears the flag.
- R10: If an event and a clear (by write or by acknowledge) fall in the same cycle, the flag ends up set.
- R11: irq_o is 1 exactly when the flag, the interrupt enable (bit 3) and gie_i are all 1.
- R12: cap_trig_o equals the level bit while the capture route (bit 2) is 1, and is 0 otherwise.
- R13: pwr_off_o follows bit 0. While bit 0 is 1, the level bit holds its value and no flag is set, whatever cmp_i does.
- R14: ref_sel_o follows bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Asynchronous comparator output |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| gie_i | input | 1 | Global interrupt enable |
| vec_ack_i | input | 1 | Interrupt vector acknowledge, clears the flag |
| irq_o | output | 1 | Interrupt request |
| cap_trig_o | output | 1 | Trigger to the capture unit |
| pwr_off_o | output | 1 | Comparator power-down control |
| ref_sel_o | output | 1 | Comparator positive-input reference select |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This shows that the level and flag latencies track the parameter and are not fixed at two cycles. The deeper chain also opens a full cycle in which the level bit has already moved but the flag has not yet been set. In that cycle the bench lines up a write-clear and an acknowledge against the pending event, which exercises the set-over-clear priority. With three stages, the frozen-synchronizer case also re-enables the block with stale content in every stage.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  localparam int unsigned REG_W = 8;

  localparam int unsigned B_OFF = 0;
  localparam int unsigned B_REF = 1;
  localparam int unsigned B_CAP = 2;
  localparam int unsigned B_IEN = 3;
  localparam int unsigned B_MLO = 4;
  localparam int unsigned B_MHI = 5;
  localparam int unsigned B_FLG = 6;
  localparam int unsigned B_LVL = 7;

  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_FALL   = 2'b10,
    MODE_RISE   = 2'b11
  } evt_mode_e;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sr_q;

  // chain freezes while disabled so no stale edge reaches the detector
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (en_i) sr_q <= {sr_q[N-2:0], d_i};
  end

  assign q_o = sr_q[N-1];
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_evt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      lvl_i,
  input  evt_mode_e mode_i,
  output logic      evt_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prev_q <= 1'b0;
    else if (en_i) prev_q <= lvl_i;
  end

  assign rise = en_i &  lvl_i & ~prev_q;
  assign fall = en_i & ~lvl_i &  prev_q;

  always_comb begin
    unique case (mode_i)
      MODE_TOGGLE: evt_o = rise | fall;
      MODE_FALL:   evt_o = fall;
      MODE_RISE:   evt_o = rise;
      default:     evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
  import cmp_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             ack_i,
  input  logic             evt_i,
  output logic             off_o,
  output logic             ref_o,
  output logic             cap_o,
  output logic             ien_o,
  output evt_mode_e        mode_o,
  output logic             flag_o
);
  logic unused_lvl;
  logic clr;

  assign unused_lvl = wr_data_i[B_LVL];
  assign clr = ack_i | (wr_en_i & wr_data_i[B_FLG]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_o  <= 1'b0;
      ref_o  <= 1'b0;
      cap_o  <= 1'b0;
      ien_o  <= 1'b0;
      mode_o <= MODE_TOGGLE;
    end else if (wr_en_i) begin
      off_o  <= wr_data_i[B_OFF];
      ref_o  <= wr_data_i[B_REF];
      cap_o  <= wr_data_i[B_CAP];
      ien_o  <= wr_data_i[B_IEN];
      mode_o <= evt_mode_e'(wr_data_i[B_MHI:B_MLO]);
    end
  end

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (evt_i) flag_o <= 1'b1;
    else if (clr)   flag_o <= 1'b0;
  end
endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             gie_i,
  input  logic             vec_ack_i,
  output logic             irq_o,
  output logic             cap_trig_o,
  output logic             pwr_off_o,
  output logic             ref_sel_o
);
  logic      lvl, evt_hit;
  logic      off, ref_s, cap_en, ien, flag;
  evt_mode_e mode;

  cmp_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (~off),
    .d_i   (cmp_i),
    .q_o   (lvl)
  );

  cmp_edge_det i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (~off),
    .lvl_i (lvl),
    .mode_i(mode),
    .evt_o (evt_hit)
  );

  cmp_ctrl_reg i_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .ack_i    (vec_ack_i),
    .evt_i    (evt_hit),
    .off_o    (off),
    .ref_o    (ref_s),
    .cap_o    (cap_en),
    .ien_o    (ien),
    .mode_o   (mode),
    .flag_o   (flag)
  );

  always_comb begin
    rd_data_o                = '0;
    rd_data_o[B_OFF]         = off;
    rd_data_o[B_REF]         = ref_s;
    rd_data_o[B_CAP]         = cap_en;
    rd_data_o[B_IEN]         = ien;
    rd_data_o[B_MHI:B_MLO]   = mode;
    rd_data_o[B_FLG]         = flag;
    rd_data_o[B_LVL]         = lvl;
  end

  assign irq_o      = flag & ien & gie_i;
  assign cap_trig_o = cap_en & lvl;
  assign pwr_off_o  = off;
  assign ref_sel_o  = ref_s;
endmodule

// File: rtl/cmp_evt_ctrl_chk.sv
module cmp_evt_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       vec_ack_i,
  input logic       evt_hit
);
  // R2
  wr_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[5:0] == $past(wr_data_i[5:0]));
  // R7
  rsvd_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[5:4] == 2'b01 && !rd_data_o[6]) |=> !rd_data_o[6]);
  // R9
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_ack_i && !evt_hit) |=> !rd_data_o[6]);
  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_hit |=> rd_data_o[6]);
  // R13
  off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[0] |=> $stable(rd_data_o[7]));
endmodule

bind cmp_evt_ctrl cmp_evt_ctrl_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o),
  .vec_ack_i(vec_ack_i),
  .evt_hit  (evt_hit)
);

// File: tb/test_cmp_evt_ctrl.sv
module test_cmp_evt_ctrl;
  localparam int unsigned SYNC = 3;

  typedef struct {
    logic [7:0] rd;
    logic [3:0] misc;  // {irq, cap, pwr_off, ref_sel}
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       gie = 1'b0;
  logic       ack = 1'b0;
  logic       irq, cap_trig, pwr_off, ref_sel;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  cmp_evt_ctrl #(.SYNC_STAGES(SYNC)) i_cmp_evt_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cmp_i     (cmp),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .gie_i     (gie),
    .vec_ack_i (ack),
    .irq_o     (irq),
    .cap_trig_o(cap_trig),
    .pwr_off_o (pwr_off),
    .ref_sel_o (ref_sel)
  );

  // monitor
  initial begin
    forever begin
      exp_t it;
      wait (q.size() != 0);
      it = q.pop_front();
      n_chk++;
      if (rd_data !== it.rd || {irq, cap_trig, pwr_off, ref_sel} !== it.misc) begin
        n_err++;
        $display("FAIL %s: rd=%h misc=%b expected rd=%h misc=%b",
                 it.tag, rd_data, {irq, cap_trig, pwr_off, ref_sel}, it.rd, it.misc);
      end
    end
  end

  task automatic chk(input logic [7:0] rd, input logic [3:0] misc, input string tag);
    exp_t it;
    #1;
    it.rd = rd; it.misc = misc; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk(8'h00, 4'b0000, "R1 reset state");

    // R2 bit 7 ignored; R13 pwr_off, R14 ref_sel follow bits
    wr(8'hFF);
    chk(8'h3F, 4'b0011, "R2 R13 R14 write all ones");
    wr(8'h00);
    chk(8'h00, 4'b0000, "R2 write zero");

    // R6 rising with R3 latency
    wr(8'h30);
    @(negedge clk); cmp = 1'b1;
    wait_n(SYNC);
    chk(8'hB0, 4'b0000, "R3 level after SYNC edges, flag pending");
    wait_n(1);
    chk(8'hF0, 4'b0000, "R6 rising sets flag");

    // R8 writing 0 to flag keeps it; R11 irq gating
    wr(8'h38);
    chk(8'hF8, 4'b0000, "R8 write 0 keeps flag, R11 gie low");
    @(negedge clk); gie = 1'b1;
    chk(8'hF8, 4'b1000, "R11 irq with flag, enable, gie");
    wr(8'h78);
    chk(8'hB8, 4'b0000, "R8 write 1 clears flag");

    @(negedge clk); cmp = 1'b0;
    wait_n(SYNC + 1);
    chk(8'h38, 4'b0000, "R6 falling ignored");

    // R5 falling mode
    wr(8'h28);
    @(negedge clk); cmp = 1'b1;
    wait_n(SYNC + 1);
    chk(8'hA8, 4'b0000, "R5 rising ignored");
    @(negedge clk); cmp = 1'b0;
    wait_n(SYNC + 1);
    chk(8'h68, 4'b1000, "R5 falling sets flag");
    pulse_ack();
    chk(8'h28, 4'b0000, "R9 ack clears flag");

    // R4 toggle mode
    wr(8'h08);
    @(negedge clk); cmp = 1'b1;
    wait_n(SYNC + 1);
    chk(8'hC8, 4'b1000, "R4 rise in toggle mode");
    pulse_ack();
    chk(8'h88, 4'b0000, "R9 ack clear");
    @(negedge clk); cmp = 1'b0;
    wait_n(SYNC + 1);
    chk(8'h48, 4'b1000, "R4 fall in toggle mode");
    pulse_ack();

    // R7 reserved mode
    wr(8'h18);
    @(negedge clk); cmp = 1'b1;
    wait_n(SYNC + 1);
    chk(8'h98, 4'b0000, "R7 reserved rise");
    @(negedge clk); cmp = 1'b0;
    wait_n(SYNC + 1);
    chk(8'h18, 4'b0000, "R7 reserved fall");

    // R10 set beats clear
    wr(8'h38);
    @(negedge clk); cmp = 1'b1;
    wait_n(SYNC - 1);
    @(negedge clk);
    ack = 1'b1; wr_en = 1'b1; wr_data = 8'h78;
    @(negedge clk);
    ack = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk(8'hF8, 4'b1000, "R10 set wins over clear");
    pulse_ack();
    chk(8'hB8, 4'b0000, "R9 clear after collision");

    // R12 capture route
    wr(8'h3C);
    chk(8'hBC, 4'b0100, "R12 route on, level high");
    @(negedge clk); cmp = 1'b0;
    wait_n(SYNC);
    chk(8'h3C, 4'b0000, "R12 route on, level low");
    @(negedge clk); cmp = 1'b1;
    wait_n(SYNC + 1);
    chk(8'hFC, 4'b1100, "R12 route follows rise");
    wr(8'h78);
    chk(8'hB8, 4'b0000, "R12 route off");

    // R13 power off freezes level, no events
    wr(8'h19);
    wr(8'h09);
    @(negedge clk); cmp = 1'b0;
    wait_n(SYNC + 3);
    chk(8'h89, 4'b0010, "R13 level held while off");
    @(negedge clk); cmp = 1'b1;
    wait_n(2);
    @(negedge clk); cmp = 1'b0;
    wait_n(SYNC + 2);
    chk(8'h89, 4'b0010, "R13 no event while off");
    wr(8'h38);
    wait_n(SYNC + 1);
    chk(8'h38, 4'b0000, "R13 re-enable, fall ignored in rise mode");

    done = 1'b1;
    finish_run();
  end
endmodule